// File: doc/BRIEF.md
# Interrupt Lifecycle State Tracker

This block holds the lifecycle of every interrupt source seen by one processor interface. Each source sits in one of four states: idle, waiting, in service, or in service with a new request waiting. Requests come in on one line per source. Each line is set up as either edge-triggered or level-triggered. The processor side delivers an acknowledge strobe and a completion strobe, each with a source number. The block reports per-source waiting and in-service flags to the priority selection logic that sits next to it. That selection logic is not part of this block.

A second acknowledge input carries acknowledges made by other processor interfaces. The lowest `NUM_SGI` source numbers are software-generated and private to each interface, so acknowledges from other interfaces do not touch them. Every higher number is a shared peripheral source. For those sources, an acknowledge on any other interface withdraws the waiting status here. A completion that names a source which is not in service is dropped and reported by a one-cycle error pulse.

Top module: `irq_lifecycle_tracker`

## Requirements
- R1: A synchronous active-high `rst` puts every source in the idle state. In the cycle after reset, `pendingOut`, `activeOut` and `eoiErr` are all zero.
- R2: An enabled source that sees a request becomes waiting, and `pendingOut[i]` rises one clock later. A source with `edgeSel[i]=1` is edge-triggered and recognises a 0→1 change of `reqIn[i]`. A source with `edgeSel[i]=0` is level-triggered and recognises `reqIn[i]` being high. A further request while the source is already waiting changes nothing.
- R3: A source with `edgeSel[i]=1` whose line stays high after acknowledge is not made waiting again. A source with `edgeSel[i]=0` whose line is still high at acknowledge stays waiting.
- R4: An acknowledge (`ackValid`, `ackId=i`) of a waiting source that is not in service sets `activeOut[i]` on the next clock. The source keeps its waiting status only if a request is recognised in that same cycle.
- R5: A completion (`eoiValid`, `eoiId=i`) of a source in service clears `activeOut[i]` on the next clock. In-service with a request waiting becomes waiting, and in-service alone becomes idle.
- R6: An acknowledge names no source unless that source is waiting, enabled and not in service. An acknowledge of a source in service with a request waiting leaves its flags unchanged.
- R7: An acknowledge from another interface (`remoteAckValid`, `remoteAckId=i`) clears the waiting status of a shared source (`i >= NUM_SGI`) and leaves its in-service flag alone. For a software-generated source (`i < NUM_SGI`) it has no effect.
- R8: While `enable[i]=0`, requests on source i are not recorded, `pendingOut[i]` is low, and an acknowledge of source i is ignored.
- R9: A completion naming a source that is not in service, or a number at or above `NUM_SRC`, changes no state. It raises `eoiErr` for exactly the following cycle.
- R10: A request recognised in the same cycle as the acknowledge of that source leaves the source in service with a request waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqIn | input | NUM_SRC | Request line per source |
| edgeSel | input | NUM_SRC | 1 = edge-triggered, 0 = level-triggered, per source |
| enable | input | NUM_SRC | Per-source enable |
| ackValid | input | 1 | Local acknowledge strobe |
| ackId | input | ID_W | Source number of the local acknowledge |
| eoiValid | input | 1 | Completion strobe |
| eoiId | input | ID_W | Source number of the completion |
| remoteAckValid | input | 1 | Acknowledge made on another interface |
| remoteAckId | input | ID_W | Source number of the remote acknowledge |
| pendingOut | output | NUM_SRC | Waiting flag per source (masked by enable) |
| activeOut | output | NUM_SRC | In-service flag per source |
| eoiErr | output | 1 | One-cycle pulse after a completion that named no in-service source |

## Verification
The bench builds the block with `NUM_SRC=6` and `NUM_SGI=2`. With six sources, the 3-bit number fields can name 6 and 7, so an out-of-range completion can be applied at the ports. Sources 0 and 1 are software-generated and sources 2 to 5 are shared. This lets a single run show a remote acknowledge clearing one source while leaving another untouched. The mix of edge-triggered and level-triggered sources puts line persistence at acknowledge and completion of the combined state within reach in both request modes.

// File: rtl/irqlc_pkg.sv
package irqlc_pkg;

  // State encoding: bit 1 = in service, bit 0 = waiting
  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_PEND    = 2'b01,
    ST_ACT     = 2'b10,
    ST_ACTPEND = 2'b11
  } lifeState_t;

  // Per-source strobes from control to datapath
  typedef struct packed {
    logic raise;      // request recognised this cycle
    logic ack;        // legal local acknowledge
    logic done;       // legal completion
    logic remoteClr;  // acknowledge from another interface on a shared source
  } srcStrobe_t;

endpackage

// File: rtl/irqlc_ctrl.sv
module irqlc_ctrl
  import irqlc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_SGI = 4,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [NUM_SRC-1:0] edgeSel,
  input  logic [NUM_SRC-1:0] enable,
  input  logic               ackValid,
  input  logic [ID_W-1:0]    ackId,
  input  logic               eoiValid,
  input  logic [ID_W-1:0]    eoiId,
  input  logic               remoteAckValid,
  input  logic [ID_W-1:0]    remoteAckId,
  input  lifeState_t         curState [NUM_SRC],
  output srcStrobe_t         strb     [NUM_SRC],
  output logic               eoiErr
);

  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] doneVec;
  logic               eoiErrQ;

  always_ff @(posedge clk) begin
    if (rst) reqPrev <= '0;
    else     reqPrev <= reqIn;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic reqSeen;
    logic remoteHit;

    always_comb begin
      if (edgeSel[i]) reqSeen = reqIn[i] & ~reqPrev[i];
      else            reqSeen = reqIn[i];
    end

    if (i < NUM_SGI) begin : g_private
      assign remoteHit = 1'b0;
    end else begin : g_shared
      assign remoteHit = remoteAckValid && (remoteAckId == ID_W'(i));
    end

    always_comb begin
      strb[i].raise     = enable[i] & reqSeen;
      strb[i].ack       = ackValid && (ackId == ID_W'(i)) && enable[i] &&
                          (curState[i] == ST_PEND);
      strb[i].done      = eoiValid && (eoiId == ID_W'(i)) && curState[i][1];
      strb[i].remoteClr = remoteHit;
      doneVec[i]        = strb[i].done;
    end
  end

  // Completion that hit nothing: flag one cycle later
  always_ff @(posedge clk) begin
    if (rst) eoiErrQ <= 1'b0;
    else     eoiErrQ <= eoiValid && (doneVec == '0);
  end

  assign eoiErr = eoiErrQ;

endmodule

// File: rtl/irqlc_datapath.sv
module irqlc_datapath
  import irqlc_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] enable,
  input  srcStrobe_t         strb     [NUM_SRC],
  output lifeState_t         curState [NUM_SRC],
  output logic [NUM_SRC-1:0] pendingOut,
  output logic [NUM_SRC-1:0] activeOut
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    lifeState_t stateQ;
    logic       nxtPend;
    logic       nxtAct;

    always_comb begin
      // Acknowledge or remote clear drop the old waiting status;
      // only a request seen in this very cycle keeps it.
      if (strb[i].ack || strb[i].remoteClr) nxtPend = strb[i].raise;
      else                                  nxtPend = stateQ[0] | strb[i].raise;

      if (strb[i].ack)       nxtAct = 1'b1;
      else if (strb[i].done) nxtAct = 1'b0;
      else                   nxtAct = stateQ[1];
    end

    always_ff @(posedge clk) begin
      if (rst) stateQ <= ST_IDLE;
      else     stateQ <= lifeState_t'({nxtAct, nxtPend});
    end

    assign curState[i]   = stateQ;
    assign pendingOut[i] = stateQ[0] & enable[i];
    assign activeOut[i]  = stateQ[1];
  end

endmodule

// File: rtl/irq_lifecycle_tracker.sv
module irq_lifecycle_tracker
  import irqlc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_SGI = 4,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [NUM_SRC-1:0] edgeSel,
  input  logic [NUM_SRC-1:0] enable,
  input  logic               ackValid,
  input  logic [ID_W-1:0]    ackId,
  input  logic               eoiValid,
  input  logic [ID_W-1:0]    eoiId,
  input  logic               remoteAckValid,
  input  logic [ID_W-1:0]    remoteAckId,
  output logic [NUM_SRC-1:0] pendingOut,
  output logic [NUM_SRC-1:0] activeOut,
  output logic               eoiErr
);

  lifeState_t curState [NUM_SRC];
  srcStrobe_t strb     [NUM_SRC];

  irqlc_ctrl #(
    .NUM_SRC(NUM_SRC),
    .NUM_SGI(NUM_SGI),
    .ID_W   (ID_W)
  ) ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .reqIn         (reqIn),
    .edgeSel       (edgeSel),
    .enable        (enable),
    .ackValid      (ackValid),
    .ackId         (ackId),
    .eoiValid      (eoiValid),
    .eoiId         (eoiId),
    .remoteAckValid(remoteAckValid),
    .remoteAckId   (remoteAckId),
    .curState      (curState),
    .strb          (strb),
    .eoiErr        (eoiErr)
  );

  irqlc_datapath #(
    .NUM_SRC(NUM_SRC)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .strb      (strb),
    .curState  (curState),
    .pendingOut(pendingOut),
    .activeOut (activeOut)
  );

endmodule

// File: rtl/irq_lifecycle_tracker_chk.sv
module irq_lifecycle_tracker_chk #(
  parameter int NUM_SRC = 16,
  parameter int NUM_SGI = 4,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] reqIn,
  input logic [NUM_SRC-1:0] edgeSel,
  input logic [NUM_SRC-1:0] enable,
  input logic               ackValid,
  input logic [ID_W-1:0]    ackId,
  input logic               eoiValid,
  input logic [ID_W-1:0]    eoiId,
  input logic               remoteAckValid,
  input logic [ID_W-1:0]    remoteAckId,
  input logic [NUM_SRC-1:0] pendingOut,
  input logic [NUM_SRC-1:0] activeOut,
  input logic               eoiErr
);

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (pendingOut == '0 && activeOut == '0 && !eoiErr));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    a_r4_ack_activates: assert property (@(posedge clk) disable iff (rst)
      (ackValid && ackId == ID_W'(i) && pendingOut[i] && !activeOut[i])
        |=> activeOut[i]);

    a_r5_eoi_retires: assert property (@(posedge clk) disable iff (rst)
      (eoiValid && eoiId == ID_W'(i) && activeOut[i]) |=> !activeOut[i]);

    a_r9_bad_eoi_flag: assert property (@(posedge clk) disable iff (rst)
      (eoiValid && eoiId == ID_W'(i) && !activeOut[i]) |=> eoiErr);

    a_r8_no_ack_when_off: assert property (@(posedge clk) disable iff (rst)
      (!enable[i] && !activeOut[i]) |=> !activeOut[i]);

    if (i < NUM_SGI) begin : g_sgi
      a_r7_private_kept: assert property (@(posedge clk) disable iff (rst)
        (remoteAckValid && remoteAckId == ID_W'(i) && pendingOut[i] &&
         !(ackValid && ackId == ID_W'(i)))
          |=> (!enable[i] || pendingOut[i]));
    end else begin : g_spi
      a_r7_shared_cleared: assert property (@(posedge clk) disable iff (rst)
        (remoteAckValid && remoteAckId == ID_W'(i) && edgeSel[i] && !reqIn[i])
          |=> !pendingOut[i]);
    end
  end

endmodule

bind irq_lifecycle_tracker irq_lifecycle_tracker_chk #(
  .NUM_SRC(NUM_SRC),
  .NUM_SGI(NUM_SGI)
) chk_i (.*);

// File: tb/irq_lifecycle_tracker_tb_top.sv
module irq_lifecycle_tracker_tb_top;

  localparam int NS = 6;
  localparam int NG = 2;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] reqIn = '0;
  logic [NS-1:0] edgeSel = 6'b101110;
  logic [NS-1:0] enable = '1;
  logic          ackValid = 1'b0;
  logic [IW-1:0] ackId = '0;
  logic          eoiValid = 1'b0;
  logic [IW-1:0] eoiId = '0;
  logic          remoteAckValid = 1'b0;
  logic [IW-1:0] remoteAckId = '0;
  logic [NS-1:0] pendingOut, activeOut;
  logic          eoiErr;

  logic [NS-1:0] expP = '0;
  logic [NS-1:0] expA = '0;
  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  irq_lifecycle_tracker #(.NUM_SRC(NS), .NUM_SGI(NG)) dut_i (
    .clk(clk), .rst(rst), .reqIn(reqIn), .edgeSel(edgeSel), .enable(enable),
    .ackValid(ackValid), .ackId(ackId), .eoiValid(eoiValid), .eoiId(eoiId),
    .remoteAckValid(remoteAckValid), .remoteAckId(remoteAckId),
    .pendingOut(pendingOut), .activeOut(activeOut), .eoiErr(eoiErr));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic expErr);
    nChecks++;
    if (pendingOut !== expP || activeOut !== expA || eoiErr !== expErr) begin
      nFails++;
      $display("FAIL %s: pend=%b act=%b err=%b expected pend=%b act=%b err=%b",
               tag, pendingOut, activeOut, eoiErr, expP, expA, expErr);
    end
  endtask

  task automatic doAck(input int id);
    ackValid = 1'b1; ackId = IW'(id);
    tick();
    ackValid = 1'b0;
  endtask

  task automatic doEoi(input int id);
    eoiValid = 1'b1; eoiId = IW'(id);
    tick();
    eoiValid = 1'b0;
  endtask

  task automatic doRemote(input int id);
    remoteAckValid = 1'b1; remoteAckId = IW'(id);
    tick();
    remoteAckValid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b0;
    reqIn[3] = 1'b1; tick();
    expP[3] = 1'b1; chk("R2 edge request before reset", 1'b0);
    reqIn[3] = 1'b0;
    rst = 1'b1; tick();
    rst = 1'b0;
    expP = '0; expA = '0;
    chk("R1 reset state", 1'b0);
  endtask

  task automatic t_edge_flow();
    reqIn[3] = 1'b1; tick();
    expP[3] = 1'b1; chk("R2 edge source becomes waiting", 1'b0);
    tick(); chk("R2 held request no change", 1'b0);
    doAck(3);
    expP[3] = 1'b0; expA[3] = 1'b1; chk("R4 ack edge source", 1'b0);
    tick(); chk("R3 held edge line no re-pend", 1'b0);
    reqIn[3] = 1'b0;
    doEoi(3);
    expA[3] = 1'b0; chk("R5 active to idle", 1'b0);
  endtask

  task automatic t_level_flow();
    reqIn[4] = 1'b1; tick();
    expP[4] = 1'b1; chk("R2 level source waiting", 1'b0);
    doAck(4);
    expA[4] = 1'b1; chk("R3 level persists at ack", 1'b0);
    doAck(4);
    chk("R6 ack of active-and-waiting ignored", 1'b0);
    reqIn[4] = 1'b0;
    doEoi(4);
    expA[4] = 1'b0; chk("R5 active-and-waiting to waiting", 1'b0);
    doAck(4);
    expA[4] = 1'b1; expP[4] = 1'b0; chk("R4 ack with line low", 1'b0);
    doEoi(4);
    expA[4] = 1'b0; chk("R5 level back to idle", 1'b0);
  endtask

  task automatic t_ack_with_request();
    reqIn[5] = 1'b1; tick();
    expP[5] = 1'b1; chk("R2 source 5 waiting", 1'b0);
    reqIn[5] = 1'b0; tick();
    reqIn[5] = 1'b1;
    doAck(5);
    expA[5] = 1'b1; chk("R10 request with ack", 1'b0);
    reqIn[5] = 1'b0;
    doEoi(5);
    expA[5] = 1'b0; chk("R5 after same-cycle request", 1'b0);
    doAck(5);
    expA[5] = 1'b1; expP[5] = 1'b0;
    doEoi(5);
    expA[5] = 1'b0; chk("R5 source 5 idle", 1'b0);
  endtask

  task automatic t_remote_ack();
    reqIn[3] = 1'b1; tick(); reqIn[3] = 1'b0;
    expP[3] = 1'b1;
    doRemote(3);
    expP[3] = 1'b0; chk("R7 shared waiting cleared", 1'b0);
    reqIn[1] = 1'b1; tick(); reqIn[1] = 1'b0;
    expP[1] = 1'b1;
    doRemote(1);
    chk("R7 private source unaffected", 1'b0);
    doAck(1);
    expP[1] = 1'b0; expA[1] = 1'b1;
    doEoi(1);
    expA[1] = 1'b0; chk("R5 source 1 idle", 1'b0);
    reqIn[3] = 1'b1; tick(); reqIn[3] = 1'b0;
    doAck(3);
    reqIn[3] = 1'b1; tick(); reqIn[3] = 1'b0;
    expA[3] = 1'b1; expP[3] = 1'b1; chk("R2 new edge while active", 1'b0);
    doRemote(3);
    expP[3] = 1'b0; chk("R7 remote keeps in-service", 1'b0);
    doEoi(3);
    expA[3] = 1'b0; chk("R5 source 3 idle", 1'b0);
  endtask

  task automatic t_disabled();
    enable[2] = 1'b0;
    reqIn[2] = 1'b1; tick(); reqIn[2] = 1'b0;
    chk("R8 disabled edge request ignored", 1'b0);
    doAck(2);
    chk("R8 disabled ack ignored", 1'b0);
    enable[0] = 1'b0;
    reqIn[0] = 1'b1; tick(); tick();
    chk("R8 disabled level ignored", 1'b0);
    reqIn[0] = 1'b0; tick();
    enable = '1; tick();
    chk("R8 nothing recorded while off", 1'b0);
  endtask

  task automatic t_bad_eoi();
    doEoi(2);
    chk("R9 eoi on idle source", 1'b1);
    tick(); chk("R9 error is one cycle", 1'b0);
    doEoi(7);
    chk("R9 eoi out of range", 1'b1);
    reqIn[4] = 1'b1; tick(); reqIn[4] = 1'b0;
    expP[4] = 1'b1;
    doEoi(4);
    chk("R9 eoi on waiting source", 1'b1);
    doAck(4);
    expP[4] = 1'b0; expA[4] = 1'b1;
    doEoi(4);
    expA[4] = 1'b0; chk("R9 legal eoi no error", 1'b0);
  endtask

  initial begin
    tick(); tick();
    t_reset();
    t_edge_flow();
    t_level_flow();
    t_ack_with_request();
    t_remote_ack();
    t_disabled();
    t_bad_eoi();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule